// File: doc/BRIEF.md
# Dual-Channel Sample Demultiplexer with Selectable A/B Alignment

This block sits between the parallel sample inputs of a two-channel converter and its internal datapath. Sample words for channels A and B arrive on two 16-bit buses. The block turns them into one aligned A/B pair per output strobe. It has three stream layouts:

- **Direct:** each bus feeds its own channel.
- **Shared:** A and B words alternate on the A bus.
- **Split:** each input cycle carries two consecutive channel-A samples, one on each bus, so channel A enters at half speed.

In shared layout the A/B phase comes from one of two places, chosen by a control bit. The first is a marker pin that flags B words. The second is the rising edge of the transmit-enable input: the first word after that edge is taken as A. Each bus can also have its bit order mirrored on its own. The layout and ordering controls are captured only while transmit-enable is low. A stream therefore never changes format partway through.

Top module: `ileave_demux`

## Requirements
- R1: While `txEnable` is sampled low (and during reset), `outValid`, `outA` and `outB` are all zero from the next clock edge on.
- R2: In direct layout (`cfgInterleave`=0, `cfgHalfRate`=0), every cycle with `txEnable` high gives `outValid`=1 one cycle later, with `outA` holding that cycle's A-bus word and `outB` holding its B-bus word.
- R3: In shared layout with edge alignment (`cfgInterleave`=1, `cfgMarkerAlign`=0), the first A-bus word after `txEnable` rises is an A sample and the next is a B sample, alternating from there. Each B word gives one strobe, one cycle later, carrying the preceding A word on `outA` and the B word on `outB`. Two strobes never occur in consecutive cycles.
- R4: In shared layout with marker alignment (`cfgMarkerAlign`=1), a word with `bMarker`=1 is a B sample and is paired with the most recent unpaired A word (`bMarker`=0). When a second A word arrives before any B word, it replaces the first.
- R5: In marker alignment, a B-flagged word with no unpaired A word before it produces no strobe.
- R6: In split layout (`cfgHalfRate`=1), each accepted input cycle yields two strobes on consecutive cycles. The first carries the A-bus word on `outA` and the second carries the B-bus word on `outA`, with `outB`=0 on both. The buses are ignored in the input cycle that produces the second strobe.
- R7: With `cfgRevA`=1, the A-bus word is mirrored, so that bus bit 0 becomes sample bit 15. With `cfgRevA`=0, bus bit 15 is the MSB.
- R8: With `cfgRevB`=1, the B-bus word is mirrored in the same way. With `cfgRevB`=0, bus bit 15 is the MSB.
- R9: Changes to the layout and ordering controls while `txEnable` is high have no effect until `txEnable` has been low for a clock edge.
- R10: Lowering `txEnable` discards any unpaired A word and resets the A/B phase. After the next rise, the first word is again an A sample.
- R11: When `cfgHalfRate` and `cfgInterleave` are both set, split layout applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Stream active; low clears outputs and allows control capture |
| cfgInterleave | input | 1 | Shared layout select (A and B alternate on A bus) |
| cfgHalfRate | input | 1 | Split layout select (channel A across both buses) |
| cfgMarkerAlign | input | 1 | 1: phase from `bMarker`; 0: phase from `txEnable` rise |
| cfgRevA | input | 1 | Mirror bit order of A bus |
| cfgRevB | input | 1 | Mirror bit order of B bus |
| bMarker | input | 1 | Flags the current A-bus word as a B sample |
| busA | input | 16 | A input bus |
| busB | input | 16 | B input bus |
| outValid | output | 1 | Aligned pair strobe |
| outA | output | 16 | Channel A sample |
| outB | output | 16 | Channel B sample |

## Verification
Distinct data words go through each layout so that the pairing is visible: a swapped, delayed or dropped word shows up as a mismatch in the ordered expectation queue. In shared layout, the stream is cut after an odd word and then restarted. This separates a phase tracker that resets from one that carries over. In marker alignment, a leading B word, back-to-back A words and back-to-back B words separate "pair with the latest A" from "pair with the first A" and from "pair with anything". Asymmetric bit patterns under mirroring expose swapped or missing reversal. Toggling controls mid-stream checks that they are captured only while idle.

// File: rtl/ileave_demux_pkg.sv
package ileave_demux_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_SHARED = 2'd1,
    MODE_SPLIT  = 2'd2
  } laneMode_e;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic clear;           // stream idle: zero outputs
    logic emitDirect;      // pass both buses through
    logic emitPair;        // held A word + current A-bus word as B
    logic emitSplitFirst;  // A-bus word as channel A sample
    logic emitSplitSecond; // held word as channel A sample
    logic holdFromA;       // capture A-bus word into hold register
    logic holdFromB;       // capture B-bus word into hold register
    logic revA;            // mirror A bus
    logic revB;            // mirror B bus
  } dpStrobe_t;

endpackage

// File: rtl/ileave_demux_ctrl.sv
module ileave_demux_ctrl
  import ileave_demux_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      cfgInterleave,
  input  logic      cfgHalfRate,
  input  logic      cfgMarkerAlign,
  input  logic      cfgRevA,
  input  logic      cfgRevB,
  input  logic      bMarker,
  output dpStrobe_t strobe,
  output laneMode_e modeQ
);

  logic      markerQ, revAQ, revBQ;
  logic      phaseQ, phaseNext;
  logic      aHaveQ, aHaveNext;
  laneMode_e modeIn;

  // split layout outranks shared layout
  always_comb begin
    if (cfgHalfRate)        modeIn = MODE_SPLIT;
    else if (cfgInterleave) modeIn = MODE_SHARED;
    else                    modeIn = MODE_DIRECT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_DIRECT;
      markerQ <= 1'b0;
      revAQ   <= 1'b0;
      revBQ   <= 1'b0;
      phaseQ  <= 1'b0;
      aHaveQ  <= 1'b0;
    end else if (!txEnable) begin
      modeQ   <= modeIn;
      markerQ <= cfgMarkerAlign;
      revAQ   <= cfgRevA;
      revBQ   <= cfgRevB;
      phaseQ  <= 1'b0;
      aHaveQ  <= 1'b0;
    end else begin
      phaseQ  <= phaseNext;
      aHaveQ  <= aHaveNext;
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.revA = revAQ;
    strobe.revB = revBQ;
    phaseNext   = phaseQ;
    aHaveNext   = aHaveQ;
    if (!txEnable) begin
      strobe.clear = 1'b1;
    end else begin
      unique case (modeQ)
        MODE_DIRECT: strobe.emitDirect = 1'b1;
        MODE_SHARED: begin
          if (markerQ) begin
            if (bMarker) begin
              if (aHaveQ) begin
                strobe.emitPair = 1'b1;
                aHaveNext       = 1'b0;
              end
            end else begin
              strobe.holdFromA = 1'b1;
              aHaveNext        = 1'b1;
            end
          end else begin
            if (!phaseQ) strobe.holdFromA = 1'b1;
            else         strobe.emitPair  = 1'b1;
            phaseNext = ~phaseQ;
          end
        end
        MODE_SPLIT: begin
          if (!phaseQ) begin
            strobe.emitSplitFirst = 1'b1;
            strobe.holdFromB      = 1'b1;
          end else begin
            strobe.emitSplitSecond = 1'b1;
          end
          phaseNext = ~phaseQ;
        end
        default: strobe.clear = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ileave_demux_dp.sv
module ileave_demux_dp
  import ileave_demux_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] busA,
  input  logic [WORD_W-1:0] busB,
  input  dpStrobe_t         strobe,
  output logic              outValid,
  output logic [WORD_W-1:0] outA,
  output logic [WORD_W-1:0] outB
);

  localparam int TOP = WORD_W - 1;

  logic [WORD_W-1:0] mirA, mirB, wordA, wordB, holdQ;

  for (genvar i = 0; i < WORD_W; i++) begin : g_mirror
    assign mirA[i] = busA[TOP-i];
    assign mirB[i] = busB[TOP-i];
  end

  assign wordA = strobe.revA ? mirA : busA;
  assign wordB = strobe.revB ? mirB : busB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (strobe.holdFromA) begin
      holdQ <= wordA;
    end else if (strobe.holdFromB) begin
      holdQ <= wordB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      outValid <= 1'b0;
      outA     <= '0;
      outB     <= '0;
    end else if (strobe.emitDirect) begin
      outValid <= 1'b1;
      outA     <= wordA;
      outB     <= wordB;
    end else if (strobe.emitPair) begin
      outValid <= 1'b1;
      outA     <= holdQ;
      outB     <= wordA;
    end else if (strobe.emitSplitFirst) begin
      outValid <= 1'b1;
      outA     <= wordA;
      outB     <= '0;
    end else if (strobe.emitSplitSecond) begin
      outValid <= 1'b1;
      outA     <= holdQ;
      outB     <= '0;
    end else begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/ileave_demux.sv
module ileave_demux
  import ileave_demux_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              cfgInterleave,
  input  logic              cfgHalfRate,
  input  logic              cfgMarkerAlign,
  input  logic              cfgRevA,
  input  logic              cfgRevB,
  input  logic              bMarker,
  input  logic [WORD_W-1:0] busA,
  input  logic [WORD_W-1:0] busB,
  output logic              outValid,
  output logic [WORD_W-1:0] outA,
  output logic [WORD_W-1:0] outB
);

  dpStrobe_t strobe;
  laneMode_e modeQ;

  ileave_demux_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable),
    .cfgInterleave(cfgInterleave), .cfgHalfRate(cfgHalfRate),
    .cfgMarkerAlign(cfgMarkerAlign), .cfgRevA(cfgRevA), .cfgRevB(cfgRevB),
    .bMarker(bMarker), .strobe(strobe), .modeQ(modeQ)
  );

  ileave_demux_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .busA(busA), .busB(busB), .strobe(strobe),
    .outValid(outValid), .outA(outA), .outB(outB)
  );

endmodule

// File: rtl/ileave_demux_chk.sv
module ileave_demux_chk
  import ileave_demux_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              txEnable,
  input logic [WORD_W-1:0] busA,
  input logic [WORD_W-1:0] busB,
  input logic              outValid,
  input logic [WORD_W-1:0] outA,
  input logic [WORD_W-1:0] outB,
  input laneMode_e         modeQ,
  input logic              revA,
  input logic              revB
);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (!outValid && outA == '0 && outB == '0));

  assert_direct_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && modeQ == MODE_DIRECT && !revA && !revB)
    |=> (outValid && outA == $past(busA) && outB == $past(busB)));

  assert_shared_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SHARED && outValid) |=> !outValid);

  assert_split_zero_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SPLIT && outValid) |-> outB == '0);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    txEnable |=> $stable(modeQ));

endmodule

bind ileave_demux ileave_demux_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .busA(busA), .busB(busB),
  .outValid(outValid), .outA(outA), .outB(outB), .modeQ(modeQ),
  .revA(strobe.revA), .revB(strobe.revB)
);

// File: tb/ileave_demux_tb_top.sv
`timescale 1ns/1ps
module ileave_demux_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, txEnable = 1'b0, bMarker = 1'b0;
  logic cfgInterleave = 1'b0, cfgHalfRate = 1'b0, cfgMarkerAlign = 1'b0;
  logic cfgRevA = 1'b0, cfgRevB = 1'b0;
  logic [15:0] busA = '0, busB = '0;
  logic outValid;
  logic [15:0] outA, outB;

  ileave_demux dut_i (
    .clk(clk), .rstN(rstN), .txEnable(txEnable),
    .cfgInterleave(cfgInterleave), .cfgHalfRate(cfgHalfRate),
    .cfgMarkerAlign(cfgMarkerAlign), .cfgRevA(cfgRevA), .cfgRevB(cfgRevB),
    .bMarker(bMarker), .busA(busA), .busB(busB),
    .outValid(outValid), .outA(outA), .outB(outB)
  );

  logic [31:0] expQ[$];
  int    vectors = 0, miscompares = 0;
  string curReq = "R1";

  function automatic logic [15:0] mirror(input logic [15:0] w);
    for (int i = 0; i < 16; i++) mirror[i] = w[15-i];
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected pairs as strobes appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) check({curReq, " unexpected strobe"}, {16'h0, outA, outB}, 48'hFFFF_0000_0000);
      else check(curReq, {16'h0, outA, outB}, {16'h0, expQ.pop_front()});
    end
  end

  task automatic word(input logic [15:0] a, input logic [15:0] b, input logic mk);
    @(negedge clk);
    txEnable = 1'b1; busA = a; busB = b; bMarker = mk;
  endtask

  // R1: after two idle cycles, outputs must read zero
  task automatic idleCheck(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      txEnable = 1'b0; bMarker = 1'b0;
    end
    check({curReq, "/R1 idle"}, {15'h0, outValid, outA, outB}, 48'h0);
    check({curReq, " leftover"}, 48'(expQ.size()), 48'h0);
  endtask

  task automatic setCfg(input logic il, input logic hr, input logic mk, input logic ra, input logic rb);
    @(negedge clk);
    txEnable = 1'b0;
    cfgInterleave = il; cfgHalfRate = hr; cfgMarkerAlign = mk; cfgRevA = ra; cfgRevB = rb;
    idleCheck(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog expired during %s actual=running expected=done", curReq);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {15'h0, outValid, outA, outB}, 48'h0);
    @(negedge clk); rstN = 1'b1;

    // R2: direct layout
    curReq = "R2";
    setCfg(0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      word(16'h1100 + 16'(i * 7), 16'h2200 + 16'(i * 13), 1'b0);
      expQ.push_back({busA, busB});
    end
    idleCheck(2);

    // R9: controls toggled mid-stream are ignored
    curReq = "R9";
    for (int i = 0; i < 5; i++) begin
      word(16'h3A00 + 16'(i), 16'h4B00 + 16'(i), 1'b1);
      expQ.push_back({busA, busB});
      cfgInterleave = 1'b1; cfgHalfRate = 1'b1; cfgRevA = 1'b1;
    end
    idleCheck(2);

    // R3: shared layout, edge alignment
    curReq = "R3";
    setCfg(1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      word(16'hA000 + 16'(i), 16'hDEAD, 1'b0);
      word(16'hB000 + 16'(i), 16'hBEEF, 1'b0);
      expQ.push_back({16'hA000 + 16'(i), 16'hB000 + 16'(i)});
    end
    idleCheck(2);

    // R10: stream cut after an odd word, restart begins with A
    curReq = "R10";
    word(16'hA111, 0, 1'b0);
    word(16'hB111, 0, 1'b0);
    expQ.push_back({16'hA111, 16'hB111});
    word(16'hA222, 0, 1'b0);
    idleCheck(2);
    word(16'hA333, 0, 1'b0);
    word(16'hB333, 0, 1'b0);
    expQ.push_back({16'hA333, 16'hB333});
    idleCheck(2);

    // R4 / R5: marker alignment
    curReq = "R5";
    setCfg(1, 0, 1, 0, 0);
    word(16'hB0B0, 0, 1'b1);           // B with no A: dropped
    word(16'h0000, 0, 1'b0);           // gap with no strobe
    curReq = "R4";
    word(16'hA001, 0, 1'b0);
    word(16'hA002, 0, 1'b0);           // replaces A001
    word(16'hB002, 0, 1'b1);
    expQ.push_back({16'hA002, 16'hB002});
    curReq = "R5";
    word(16'hB003, 0, 1'b1);           // second B: dropped
    curReq = "R4";
    word(16'hA004, 0, 1'b0);
    word(16'hB004, 0, 1'b1);
    expQ.push_back({16'hA004, 16'hB004});
    idleCheck(2);

    // R6: split layout
    curReq = "R6";
    setCfg(0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      word(16'h5000 + 16'(i), 16'h6000 + 16'(i), 1'b0);
      expQ.push_back({16'h5000 + 16'(i), 16'h0000});
      expQ.push_back({16'h6000 + 16'(i), 16'h0000});
      word(16'hFFFF, 16'hEEEE, 1'b1);  // ignored second cycle
    end
    idleCheck(2);

    // R11: split wins over shared
    curReq = "R11";
    setCfg(1, 1, 0, 0, 0);
    word(16'h7123, 16'h8456, 1'b0);
    expQ.push_back({16'h7123, 16'h0000});
    expQ.push_back({16'h8456, 16'h0000});
    word(16'h1111, 16'h2222, 1'b0);
    idleCheck(2);

    // R7: A bus mirrored only
    curReq = "R7";
    setCfg(0, 0, 0, 1, 0);
    word(16'h0001, 16'h0003, 1'b0); expQ.push_back({mirror(16'h0001), 16'h0003});
    word(16'h12C4, 16'h00F0, 1'b0); expQ.push_back({mirror(16'h12C4), 16'h00F0});
    idleCheck(2);

    // R8: B bus mirrored only
    curReq = "R8";
    setCfg(0, 0, 0, 0, 1);
    word(16'h0003, 16'h0001, 1'b0); expQ.push_back({16'h0003, mirror(16'h0001)});
    word(16'h00F0, 16'hA5C3, 1'b0); expQ.push_back({16'h00F0, mirror(16'hA5C3)});
    idleCheck(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule